// File: doc/BRIEF.md
# Translation Unit Control Register Block

This block is the register file that software uses to manage a TLB-based address translator. It holds a process identifier, a zone-protection word and an entry index. Two window registers give access to the tag word and the data word of the translation entry that the index selects. A search register takes an effective address, asks the translator for a matching entry, and records the result in the index register.

Requests arrive on a simple one-cycle register bus that has a 3-bit register number. The entry storage and the associative lookup belong to the translator. This block drives their write strobes and the search address, and it reads their combinational responses in the same cycle. An access-level input limits what the bus master may do. When the process identifier or the zone word is written with a new value, the block emits a one-cycle invalidate pulse so that downstream translation caches can drop stale results.

Top module: `mmu_sreg_ctrl`

## Requirements
- R1: After reset the process identifier, zone word and index register are all zero, `inv_pulse` is low, and every register reads as zero.
- R2: Register numbers are 0 for the process identifier (8 bits, zero-extended on read, taken from `req_wdata[7:0]` on write), 1 for the 32-bit zone word, 2 for the index, 3 for search, 4 for the entry data word and 5 for the entry tag word. `rsp_valid` and `rsp_rdata` appear in the cycle after a read request.
- R3: A write to the index register replaces bits 30:0. Bit 31 is the miss flag and keeps its value. Bits 7:0 of the index select the entry presented on `ent_idx`.
- R4: A write to register 4 pulses `ent_lo_we` with `ent_wdata` equal to the written word. A write to register 5 pulses `ent_hi_we` and stores the current process identifier as the entry's translation ID through `ent_tid_wdata`.
- R5: A read of register 5 returns the selected tag word and loads the process identifier from that entry's translation ID. A read of register 4 returns the data word and leaves the process identifier unchanged.
- R6: A write to the search register on which the lookup reports a hit sets the index register to the zero-extended hit index, which clears the miss flag.
- R7: A search write on which the lookup misses sets bit 31 of the index register and leaves bits 30:0 unchanged.
- R8: The search register and the undefined numbers 6 and 7 read as zero. Writes to 6 and 7 change nothing.
- R9: At access level 0 every write is ignored and every read returns zero, including a read of register 5, which then does not load the process identifier.
- R10: At access level 1 reads are allowed, writes to the index and entry registers are allowed, and writes to the process identifier, the zone word and the search register are ignored.
- R11: At access levels 2 and 3 all registers can be written and read.
- R12: `inv_pulse` is high for exactly the cycle after an accepted write to the process identifier or the zone word that changes its value. It stays low when the written value equals the held one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_level | input | 2 | Access level granted to the bus master |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register number |
| req_wdata | input | 32 | Write data, also the search address |
| rsp_valid | output | 1 | Read response valid (one cycle after the request) |
| rsp_rdata | output | 32 | Read response data |
| ent_idx | output | 8 | Selected entry index |
| ent_hi_we | output | 1 | Tag-word write strobe |
| ent_lo_we | output | 1 | Data-word write strobe |
| ent_wdata | output | 32 | Word written to the entry |
| ent_tid_wdata | output | 8 | Translation ID written with the tag word |
| ent_hi_rdata | input | 32 | Tag word of the selected entry |
| ent_lo_rdata | input | 32 | Data word of the selected entry |
| ent_tid_rdata | input | 8 | Translation ID of the selected entry |
| lk_valid | output | 1 | Search lookup request |
| lk_vaddr | output | 32 | Address to search for |
| lk_hit | input | 1 | Lookup hit (combinational response) |
| lk_idx | input | 8 | Index of the hit entry |
| inv_pulse | output | 1 | One-cycle invalidate request |

## Verification
Entry write strobes and the search request are combinational outputs in the request cycle. They are captured by the bench's storage model at the same clock edge. Read data, `rsp_valid`, `inv_pulse` and every register update, including a search result and a process identifier reloaded by a tag read, become visible one cycle after the request edge. The bench therefore applies each request at a falling edge and samples 1 ns after the next rising edge. It then issues the next request, so the value read at a later access always reflects the previous one. The bench repeats the same access sweep at each of the four access levels, and a reference model computes the expected results and applies the permission rules.

// File: rtl/mmu_sreg_pkg.sv
package mmu_sreg_pkg;

    localparam logic [2:0] RN_PID  = 3'd0;
    localparam logic [2:0] RN_ZPR  = 3'd1;
    localparam logic [2:0] RN_IDX  = 3'd2;
    localparam logic [2:0] RN_SRCH = 3'd3;
    localparam logic [2:0] RN_LO   = 3'd4;
    localparam logic [2:0] RN_HI   = 3'd5;

    localparam logic [1:0] LVL_NONE = 2'd0;
    localparam logic [1:0] LVL_READ = 2'd1;

    typedef struct packed {
        logic pid_wr;
        logic zpr_wr;
        logic idx_wr;
        logic srch_wr;
        logic lo_wr;
        logic hi_wr;
        logic rd_pid;
        logic rd_zpr;
        logic rd_idx;
        logic rd_lo;
        logic rd_hi;
        logic rd_any;
    } sreg_op_t;

endpackage

// File: rtl/mmu_sreg_decode.sv
module mmu_sreg_decode
    import mmu_sreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_level,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic [2:0] req_addr,
    output sreg_op_t   op
);

    logic rd_ok;
    logic wr_full;
    logic wr_basic;
    logic is_rd;
    logic is_wr;

    always_comb begin
        rd_ok    = (cfg_level != LVL_NONE);
        wr_basic = (cfg_level != LVL_NONE);
        wr_full  = (cfg_level != LVL_NONE) && (cfg_level != LVL_READ);
        is_rd    = req_valid && !req_write;
        is_wr    = req_valid && req_write;

        op        = '0;
        op.rd_any = is_rd;
        case (req_addr)
            RN_PID: begin
                op.pid_wr = is_wr && wr_full;
                op.rd_pid = is_rd && rd_ok;
            end
            RN_ZPR: begin
                op.zpr_wr = is_wr && wr_full;
                op.rd_zpr = is_rd && rd_ok;
            end
            RN_IDX: begin
                op.idx_wr = is_wr && wr_basic;
                op.rd_idx = is_rd && rd_ok;
            end
            RN_SRCH: begin
                op.srch_wr = is_wr && wr_full;
            end
            RN_LO: begin
                op.lo_wr = is_wr && wr_basic;
                op.rd_lo = is_rd && rd_ok;
            end
            RN_HI: begin
                op.hi_wr = is_wr && wr_basic;
                op.rd_hi = is_rd && rd_ok;
            end
            default: ;
        endcase
    end

    // R9
    no_lvl0_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_level == LVL_NONE) |-> !(op.pid_wr || op.zpr_wr || op.idx_wr ||
            op.srch_wr || op.lo_wr || op.hi_wr || op.rd_pid || op.rd_zpr ||
            op.rd_idx || op.rd_lo || op.rd_hi));

    // R10
    lvl1_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_level == LVL_READ) |-> !(op.pid_wr || op.zpr_wr || op.srch_wr));

endmodule

// File: rtl/mmu_sreg_state.sv
module mmu_sreg_state
    import mmu_sreg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PID_W  = 8,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sreg_op_t          op,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PID_W-1:0]  ent_tid_rdata,
    input  logic              lk_hit,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic [PID_W-1:0]  pid_q,
    output logic [DATA_W-1:0] zpr_q,
    output logic [DATA_W-1:0] tlbx_q,
    output logic              inv_q
);

    localparam int MISS_BIT = DATA_W - 1;

    typedef struct packed {
        logic [PID_W-1:0]  pid;
        logic [DATA_W-1:0] zpr;
        logic [DATA_W-1:0] tlbx;
        logic              inv;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.inv = 1'b0;
        if (op.pid_wr) begin
            st_d.pid = wdata[PID_W-1:0];
            st_d.inv = (wdata[PID_W-1:0] != st_q.pid);
        end
        if (op.zpr_wr) begin
            st_d.zpr = wdata;
            st_d.inv = (wdata != st_q.zpr);
        end
        if (op.idx_wr) begin
            st_d.tlbx = {st_q.tlbx[MISS_BIT], wdata[MISS_BIT-1:0]};
        end
        if (op.srch_wr) begin
            if (lk_hit) begin
                st_d.tlbx = DATA_W'(lk_idx);
            end else begin
                st_d.tlbx[MISS_BIT] = 1'b1;
            end
        end
        if (op.rd_hi) begin
            st_d.pid = ent_tid_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pid_q  = st_q.pid;
    assign zpr_q  = st_q.zpr;
    assign tlbx_q = st_q.tlbx;
    assign inv_q  = st_q.inv;

    // R3
    miss_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op.idx_wr |=> tlbx_q[MISS_BIT] == $past(tlbx_q[MISS_BIT]));

    // R6
    search_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op.srch_wr && lk_hit) |=> tlbx_q == DATA_W'($past(lk_idx)));

    // R7
    search_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op.srch_wr && !lk_hit) |=> tlbx_q[MISS_BIT] &&
            (tlbx_q[MISS_BIT-1:0] == $past(tlbx_q[MISS_BIT-1:0])));

    // R5
    pid_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op.rd_hi |=> pid_q == $past(ent_tid_rdata));

    // R12
    inv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_q |-> (pid_q != $past(pid_q)) || (zpr_q != $past(zpr_q)));

endmodule

// File: rtl/mmu_sreg_rdmux.sv
module mmu_sreg_rdmux
    import mmu_sreg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PID_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sreg_op_t          op,
    input  logic [PID_W-1:0]  pid,
    input  logic [DATA_W-1:0] zpr,
    input  logic [DATA_W-1:0] tlbx,
    input  logic [DATA_W-1:0] ent_hi_rdata,
    input  logic [DATA_W-1:0] ent_lo_rdata,
    output logic              rvalid_q,
    output logic [DATA_W-1:0] rdata_q
);

    logic              rvalid_d;
    logic [DATA_W-1:0] rdata_d;

    always_comb begin
        rvalid_d = op.rd_any;
        rdata_d  = '0;
        if (op.rd_pid) rdata_d = DATA_W'(pid);
        if (op.rd_zpr) rdata_d = zpr;
        if (op.rd_idx) rdata_d = tlbx;
        if (op.rd_lo)  rdata_d = ent_lo_rdata;
        if (op.rd_hi)  rdata_d = ent_hi_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= rvalid_d;
            rdata_q  <= rdata_d;
        end
    end

    // R8
    no_source_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op.rd_pid || op.rd_zpr || op.rd_idx || op.rd_lo || op.rd_hi)
            |=> rdata_q == '0);

endmodule

// File: rtl/mmu_sreg_ctrl.sv
module mmu_sreg_ctrl
    import mmu_sreg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PID_W  = 8,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_level,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [2:0]        req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [IDX_W-1:0]  ent_idx,
    output logic              ent_hi_we,
    output logic              ent_lo_we,
    output logic [DATA_W-1:0] ent_wdata,
    output logic [PID_W-1:0]  ent_tid_wdata,
    input  logic [DATA_W-1:0] ent_hi_rdata,
    input  logic [DATA_W-1:0] ent_lo_rdata,
    input  logic [PID_W-1:0]  ent_tid_rdata,
    output logic              lk_valid,
    output logic [DATA_W-1:0] lk_vaddr,
    input  logic              lk_hit,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              inv_pulse
);

    sreg_op_t          op;
    logic [PID_W-1:0]  pid_q;
    logic [DATA_W-1:0] zpr_q;
    logic [DATA_W-1:0] tlbx_q;

    mmu_sreg_decode u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_level (cfg_level),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .op        (op)
    );

    mmu_sreg_state #(
        .DATA_W (DATA_W),
        .PID_W  (PID_W),
        .IDX_W  (IDX_W)
    ) u_state (
        .clk           (clk),
        .rst_n         (rst_n),
        .op            (op),
        .wdata         (req_wdata),
        .ent_tid_rdata (ent_tid_rdata),
        .lk_hit        (lk_hit),
        .lk_idx        (lk_idx),
        .pid_q         (pid_q),
        .zpr_q         (zpr_q),
        .tlbx_q        (tlbx_q),
        .inv_q         (inv_pulse)
    );

    mmu_sreg_rdmux #(
        .DATA_W (DATA_W),
        .PID_W  (PID_W)
    ) u_rdmux (
        .clk          (clk),
        .rst_n        (rst_n),
        .op           (op),
        .pid          (pid_q),
        .zpr          (zpr_q),
        .tlbx         (tlbx_q),
        .ent_hi_rdata (ent_hi_rdata),
        .ent_lo_rdata (ent_lo_rdata),
        .rvalid_q     (rsp_valid),
        .rdata_q      (rsp_rdata)
    );

    assign ent_idx       = tlbx_q[IDX_W-1:0];
    assign ent_hi_we     = op.hi_wr;
    assign ent_lo_we     = op.lo_wr;
    assign ent_wdata     = req_wdata;
    assign ent_tid_wdata = pid_q;
    assign lk_valid      = op.srch_wr;
    assign lk_vaddr      = req_wdata;

    // R4
    tid_with_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_hi_we |-> (ent_tid_wdata == pid_q) && !ent_lo_we);

    // R2
    rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

endmodule

// File: tb/mmu_sreg_ctrl_tb.sv
`timescale 1ns/1ps
module mmu_sreg_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_level = 2'd0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_addr = 3'd0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [7:0]  ent_idx;
    logic        ent_hi_we, ent_lo_we;
    logic [31:0] ent_wdata;
    logic [7:0]  ent_tid_wdata;
    logic [31:0] ent_hi_rdata, ent_lo_rdata;
    logic [7:0]  ent_tid_rdata;
    logic        lk_valid;
    logic [31:0] lk_vaddr;
    logic        lk_hit;
    logic [7:0]  lk_idx;
    logic        inv_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mmu_sreg_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ent_idx(ent_idx), .ent_hi_we(ent_hi_we), .ent_lo_we(ent_lo_we),
        .ent_wdata(ent_wdata), .ent_tid_wdata(ent_tid_wdata),
        .ent_hi_rdata(ent_hi_rdata), .ent_lo_rdata(ent_lo_rdata),
        .ent_tid_rdata(ent_tid_rdata), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_idx(lk_idx), .inv_pulse(inv_pulse)
    );

    // external entry storage and lookup stand-in
    logic [31:0] mem_hi  [256];
    logic [31:0] mem_lo  [256];
    logic [7:0]  mem_tid [256];

    always @(posedge clk) begin
        if (ent_hi_we) begin
            mem_hi[ent_idx]  <= ent_wdata;
            mem_tid[ent_idx] <= ent_tid_wdata;
        end
        if (ent_lo_we) mem_lo[ent_idx] <= ent_wdata;
    end
    assign ent_hi_rdata  = mem_hi[ent_idx];
    assign ent_lo_rdata  = mem_lo[ent_idx];
    assign ent_tid_rdata = mem_tid[ent_idx];
    assign lk_hit = (lk_vaddr[31:24] == 8'hA5);
    assign lk_idx = lk_vaddr[7:0];

    // reference model
    logic [7:0]  m_pid = '0;
    logic [31:0] m_zpr = '0;
    logic [31:0] m_tlbx = '0;
    logic [31:0] x_hi  [256];
    logic [31:0] x_lo  [256];
    logic [7:0]  x_tid [256];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input logic we, input logic [2:0] a, input logic [31:0] wd, input string req);
        logic [31:0] er;
        logic        ei;
        logic [7:0]  ix;
        logic        wok;
        er  = '0;
        ei  = 1'b0;
        ix  = m_tlbx[7:0];
        wok = (cfg_level >= 2) || (cfg_level == 1 && (a == 3'd2 || a == 3'd4 || a == 3'd5));
        if (we) begin
            if (wok) begin
                case (a)
                    3'd0: begin ei = (wd[7:0] != m_pid); m_pid = wd[7:0]; end
                    3'd1: begin ei = (wd != m_zpr); m_zpr = wd; end
                    3'd2: m_tlbx = {m_tlbx[31], wd[30:0]};
                    3'd3: if (wd[31:24] == 8'hA5) m_tlbx = {24'd0, wd[7:0]};
                          else m_tlbx[31] = 1'b1;
                    3'd4: x_lo[ix] = wd;
                    3'd5: begin x_hi[ix] = wd; x_tid[ix] = m_pid; end
                    default: ;
                endcase
            end
        end else if (cfg_level != 0) begin
            case (a)
                3'd0: er = {24'd0, m_pid};
                3'd1: er = m_zpr;
                3'd2: er = m_tlbx;
                3'd4: er = x_lo[ix];
                3'd5: begin er = x_hi[ix]; m_pid = x_tid[ix]; end
                default: er = '0;
            endcase
        end
        @(negedge clk);
        req_valid = 1'b1;
        req_write = we;
        req_addr  = a;
        req_wdata = wd;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        check({req, " rsp_valid"}, {31'd0, rsp_valid}, {31'd0, !we});
        if (!we) check({req, " rdata"}, rsp_rdata, er);
        check({req, " inv_pulse"}, {31'd0, inv_pulse}, {31'd0, ei});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            x_hi[i] = '0; x_lo[i] = '0; x_tid[i] = '0;
        end
        repeat (4) @(posedge clk);
        #1;
        check("R1 inv after reset", {31'd0, inv_pulse}, 32'd0);
        check("R1 rdata after reset", rsp_rdata, 32'd0);
        rst_n = 1'b1;
        cfg_level = 2'd3;
        for (int a = 0; a < 8; a++) acc(1'b0, 3'(a), '0, "R1 reset read");

        for (int l = 0; l < 4; l++) begin
            cfg_level = 2'(l);
            acc(1'b1, 3'd0, 32'hFFFF_FF21 + 32'(l), "R11/R10/R9 pid write R12");
            acc(1'b0, 3'd0, '0, "R2 pid read");
            acc(1'b1, 3'd0, 32'h0000_0021 + 32'(l), "R12 same pid");
            acc(1'b1, 3'd1, 32'hC3A5_0F00 ^ 32'(l), "R12 zpr write");
            acc(1'b0, 3'd1, '0, "R2 zpr read");
            acc(1'b1, 3'd1, 32'hC3A5_0F00 ^ 32'(l), "R12 same zpr");
            acc(1'b1, 3'd2, 32'h0000_0040 + 32'(l), "R3 idx write");
            acc(1'b1, 3'd5, 32'hABCD_E000 | 32'(l), "R4 tag write");
            acc(1'b1, 3'd4, 32'h1234_5600 | 32'(l), "R4 data write");
            acc(1'b1, 3'd0, 32'h0000_0090 + 32'(l), "R12 pid change");
            acc(1'b0, 3'd5, '0, "R5 tag read");
            acc(1'b0, 3'd0, '0, "R5 pid reloaded");
            acc(1'b0, 3'd4, '0, "R5 data read");
            acc(1'b0, 3'd0, '0, "R5 pid kept");
            acc(1'b1, 3'd3, 32'h1100_0000, "R7 search miss");
            acc(1'b0, 3'd2, '0, "R7 idx after miss");
            acc(1'b1, 3'd2, 32'h0000_0013, "R3 idx write keeps flag");
            acc(1'b0, 3'd2, '0, "R3 idx read");
            acc(1'b1, 3'd3, 32'hA500_0077, "R6 search hit");
            acc(1'b0, 3'd2, '0, "R6 idx after hit");
            acc(1'b1, 3'd2, 32'h8000_0055, "R3 flag not writable");
            acc(1'b0, 3'd2, '0, "R3 idx read flag");
            acc(1'b0, 3'd3, '0, "R8 search reads zero");
            acc(1'b1, 3'd6, 32'hDEAD_BEEF, "R8 undef write");
            acc(1'b0, 3'd6, '0, "R8 undef read");
            acc(1'b0, 3'd7, '0, "R8 undef read");
            acc(1'b0, 3'd1, '0, "R8 zpr untouched");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule